// File: doc/BRIEF.md
# ADC Conversion Handshake Controller

This block runs the host side of a sampling converter's single-shot conversion handshake. When the user side raises a start request while the controller is idle, it sends an active-low conversion-start pulse of programmable width. It then waits for the converter's active-low end-of-conversion interrupt, and after that it reads the result with chip-select/read strobes. In parallel mode one read returns all 14 bits. In byte mode a low-byte read and a high-byte read are issued, steered by a byte-select output, and the two bytes are joined. The finished word appears on `result_data` with a one-clock `result_valid` pulse.

The controller guards the converter against misuse. It never strobes a read while a conversion is in flight, and it ignores further start requests until the current transaction has ended. The interrupt is brought through a two-flop synchronizer. If the interrupt is still low once reset has settled, or after a timeout, one dummy read clears it and delivers no result. If the interrupt does not arrive within a parameterised number of cycles, a one-cycle `timeout_err` pulse is raised.

Top module: `adc_hs_ctrl`

## Requirements
- R1: During and right after reset, `conv_start_n`, `cs_n` and `rd_n` are high, and `hben`, `result_valid` and `timeout_err` are low.
- R2: A `start_req` seen in idle drives `conv_start_n` low for exactly CONV_LOW_CYC cycles. It then returns high and stays high until the transaction ends.
- R3: `cs_n`/`rd_n` are never low while `conv_start_n` is low or while a started conversion has not yet signalled completion on `int_n`. A new start pulse is never issued while the converter is still converting.
- R4: Each read holds `cs_n` and `rd_n` low together for exactly RD_LOW_CYC cycles.
- R5: With BYTE_MODE=0, one read is made per conversion and `result_data` = {2'b00, adc_bus[13:0]} as sampled in that read.
- R6: With BYTE_MODE=1, the first read has `hben`=0 and takes adc_bus[7:0] as result bits 7:0. The second read follows after exactly RD_GAP_CYC cycles with both strobes high, has `hben`=1, and takes adc_bus[5:0] as result bits 13:8. adc_bus[13:8] and bits 7:6 of the high read are ignored.
- R7: `result_valid` is high for exactly one clock per completed conversion, and result bits 15:14 are always zero.
- R8: A `start_req` raised while a transaction is under way is ignored: exactly one start pulse and one result follow.
- R9: If `int_n` does not fall within INT_TIMEOUT_CYC cycles after the start pulse ends, `timeout_err` pulses for one clock, no read is made, no result is given, and later starts work.
- R10: If `int_n` is low once the synchronizer has settled after reset, exactly one read with `hben`=0 is made and no result is given. Normal conversions follow.
- R11: `hben` does not change while a read strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion (taken only when idle) |
| result_valid | output | 1 | One-cycle pulse: result_data holds a new result |
| result_data | output | 16 | Assembled result, bits 15:14 zero |
| timeout_err | output | 1 | One-cycle pulse: no end-of-conversion seen in time |
| conv_start_n | output | 1 | Active-low conversion-start pulse to the converter |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| hben | output | 1 | Byte select: 0 low byte, 1 high byte |
| int_n | input | 1 | Active-low end-of-conversion interrupt (asynchronous) |
| adc_bus | input | 14 | Converter data bus (bits 7:0 only in byte mode) |

## Verification
The bench builds two instances side by side, one with BYTE_MODE=0 and one with BYTE_MODE=1. Both use CONV_LOW_CYC=3, RD_LOW_CYC=2, RD_GAP_CYC=2 and INT_TIMEOUT_CYC=40, and each is driven by its own converter model that converts in ten cycles. These short windows make a conversion last only a few dozen cycles. That lets one run sweep every data bit in walking and dense code patterns in both read formats, and still reach the timeout path and the power-up dummy read within its cycle budget.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;

  localparam int BUS_W = 14;
  localparam int RES_W = 16;
  localparam int SYNC_SETTLE = 2;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } hs_state_e;

  // high read carries bits 13:8 in its low six lines
  function automatic logic [RES_W-1:0] join_bytes(input logic [7:0] lo,
                                                   input logic [7:0] hi);
    return {2'b00, hi[5:0], lo};
  endfunction

  function automatic logic [RES_W-1:0] pad_word(input logic [BUS_W-1:0] w);
    return {2'b00, w};
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/adc_hs_timer.sv
module adc_hs_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= W'(RST_VAL);
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_TMR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));   // R2

  AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));   // R4

endmodule

// File: rtl/adc_hs_assemble.sv
module adc_hs_assemble
  import adc_hs_pkg::*;
#(
  parameter bit BYTE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             high_sel,
  input  logic [BUS_W-1:0] bus,
  output logic [RES_W-1:0] word
);

  logic [RES_W-1:0] word_q;

  generate
    if (BYTE_MODE) begin : g_byte
      logic [7:0] lo_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo_q   <= '0;
          word_q <= '0;
        end else if (capture) begin
          if (!high_sel) lo_q   <= bus[7:0];
          else           word_q <= join_bytes(lo_q, bus[7:0]);
        end
      end
    end else begin : g_par
      always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= pad_word(bus);
      end
    end
  endgenerate

  assign word = word_q;

  AST_WORD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[RES_W-1:BUS_W] == '0);   // R7

endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
  import adc_hs_pkg::*;
#(
  parameter bit BYTE_MODE       = 1'b0,
  parameter int CONV_LOW_CYC    = 4,
  parameter int RD_LOW_CYC      = 3,
  parameter int RD_GAP_CYC      = 2,
  parameter int INT_TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  output logic             result_valid,
  output logic [15:0]      result_data,
  output logic             timeout_err,
  output logic             conv_start_n,
  output logic             cs_n,
  output logic             rd_n,
  output logic             hben,
  input  logic             int_n,
  input  logic [13:0]      adc_bus
);

  localparam int MAXC = max4(CONV_LOW_CYC, RD_LOW_CYC, RD_GAP_CYC, INT_TIMEOUT_CYC);
  localparam int TW   = $clog2(MAXC + 1) + 1;

  hs_state_e st_q, st_n;
  logic half_q, half_n, dummy_q, dummy_n, more_q, more_n;
  logic int_meta_q, int_sync_q;
  logic tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic cap, fin, to_pulse, last_read;
  logic conv_q, cs_q, rd_q, valid_q, to_q;

  // two-flop synchronizer for the asynchronous interrupt
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_meta_q <= 1'b1;
      int_sync_q <= 1'b1;
    end else begin
      int_meta_q <= int_n;
      int_sync_q <= int_meta_q;
    end
  end

  adc_hs_timer #(.W(TW), .RST_VAL(SYNC_SETTLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  assign last_read = dummy_q || !BYTE_MODE || half_q;

  always_comb begin
    st_n     = st_q;
    half_n   = half_q;
    dummy_n  = dummy_q;
    more_n   = more_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    fin      = 1'b0;
    to_pulse = 1'b0;
    unique case (st_q)
      ST_PWRUP: if (tmr_exp) begin
        if (!int_sync_q) begin
          st_n     = ST_READ;
          dummy_n  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(RD_LOW_CYC - 1);
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_IDLE: begin
        half_n  = 1'b0;
        dummy_n = 1'b0;
        more_n  = 1'b0;
        if (start_req) begin
          st_n     = ST_CONV;
          tmr_load = 1'b1;
          tmr_val  = TW'(CONV_LOW_CYC - 1);
        end
      end
      ST_CONV: if (tmr_exp) begin
        st_n     = ST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TW'(INT_TIMEOUT_CYC - 1);
      end
      ST_WAIT: begin
        if (!int_sync_q) begin
          st_n     = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = TW'(RD_LOW_CYC - 1);
        end else if (tmr_exp) begin
          st_n     = ST_PWRUP;
          to_pulse = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(SYNC_SETTLE);
        end
      end
      ST_READ: if (tmr_exp) begin
        st_n     = ST_GAP;
        tmr_load = 1'b1;
        tmr_val  = TW'(RD_GAP_CYC - 1);
        cap      = !dummy_q;
        fin      = !dummy_q && last_read;
        if (!last_read) begin
          half_n = 1'b1;
          more_n = 1'b1;
        end
      end
      ST_GAP: if (tmr_exp) begin
        if (more_q) begin
          st_n     = ST_READ;
          more_n   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TW'(RD_LOW_CYC - 1);
        end else begin
          st_n = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_PWRUP;
      half_q  <= 1'b0;
      dummy_q <= 1'b0;
      more_q  <= 1'b0;
      conv_q  <= 1'b1;
      cs_q    <= 1'b1;
      rd_q    <= 1'b1;
      valid_q <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      st_q    <= st_n;
      half_q  <= half_n;
      dummy_q <= dummy_n;
      more_q  <= more_n;
      conv_q  <= (st_n != ST_CONV);
      cs_q    <= (st_n != ST_READ);
      rd_q    <= (st_n != ST_READ);
      valid_q <= fin;
      to_q    <= to_pulse;
    end
  end

  adc_hs_assemble #(.BYTE_MODE(BYTE_MODE)) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (cap),
    .high_sel(half_q),
    .bus     (adc_bus),
    .word    (result_data)
  );

  assign conv_start_n = conv_q;
  assign cs_n         = cs_q;
  assign rd_n         = rd_q;
  assign hben         = half_q;
  assign result_valid = valid_q;
  assign timeout_err  = to_q;

  AST_NO_READ_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !cs_n) |-> conv_start_n);   // R3

  AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n == rd_n);   // R4

  AST_VALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);   // R7

  AST_RESULT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result_data[15:14] == 2'b00));   // R7

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start_n) |-> $past(st_q == ST_IDLE && start_req));   // R8

  AST_TIMEOUT_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!result_valid && cs_n));   // R9

  AST_HBEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(hben));   // R11

endmodule

// File: tb/test_adc_hs_ctrl.sv
module adc_conv_model #(
  parameter int CONV_CYC = 10,
  parameter bit BYTE     = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        hben,
  input  logic [13:0] sample,
  input  logic        hold,
  input  logic        pwr_low,
  output logic        int_n,
  output logic [13:0] bus,
  output int          conv_w,
  output int          rd_w,
  output int          gap_w,
  output int          n_reads,
  output int          n_convs,
  output int          viol,
  output logic [1:0]  hben_seq
);
  logic strobe, prev_conv, prev_strobe, converting;
  int conv_cnt, rd_cnt, gap_cnt, busy_cnt;

  assign strobe = !cs_n && !rd_n;

  initial begin
    n_reads = 0; n_convs = 0; viol = 0; conv_w = 0; rd_w = 0; gap_w = 0;
    hben_seq = 2'b00; int_n = 1'b1;
  end

  always_comb begin
    if (!strobe)  bus = 14'h2D2D;
    else if (BYTE) bus = {6'h2A, (hben ? {2'b11, sample[13:8]} : sample[7:0])};
    else           bus = sample;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      int_n <= !pwr_low; converting <= 1'b0; prev_conv <= 1'b1; prev_strobe <= 1'b0;
      conv_cnt <= 0; rd_cnt <= 0; gap_cnt <= 0; busy_cnt <= 0;
    end else begin
      prev_conv <= conv_n;
      prev_strobe <= strobe;
      if (converting) begin
        if (busy_cnt <= 1) begin
          converting <= 1'b0;
          if (!hold) int_n <= 1'b0;
        end else busy_cnt <= busy_cnt - 1;
      end
      if (!conv_n) conv_cnt <= conv_cnt + 1;
      if (!conv_n && prev_conv) begin
        n_convs <= n_convs + 1;
        if (converting) viol <= viol + 1;
      end
      if (conv_n && !prev_conv) begin
        conv_w <= conv_cnt; conv_cnt <= 0; converting <= 1'b1; busy_cnt <= CONV_CYC;
      end
      if (strobe) rd_cnt <= rd_cnt + 1; else gap_cnt <= gap_cnt + 1;
      if (strobe && !prev_strobe) begin
        n_reads <= n_reads + 1; int_n <= 1'b1;
        hben_seq <= {hben_seq[0], hben}; gap_w <= gap_cnt;
        if (converting || !conv_n) viol <= viol + 1;
      end
      if (!strobe && prev_strobe) begin
        rd_w <= rd_cnt; rd_cnt <= 0; gap_cnt <= 1;
      end
    end
  end
endmodule

module test_adc_hs_ctrl;
  localparam int CONV_LOW = 3;
  localparam int RD_LOW   = 2;
  localparam int GAP      = 2;
  localparam int TMO      = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [13:0] sample = '0;
  logic hold = 1'b0;
  logic pwr_low = 1'b0;

  logic valid_p, valid_b, to_p, to_b, conv_p, conv_b, cs_p, cs_b, rd_p, rd_b, hb_p, hb_b;
  logic int_p, int_b;
  logic [15:0] data_p, data_b;
  logic [13:0] bus_p, bus_b;
  int cw_p, cw_b, rw_p, rw_b, gw_p, gw_b, nr_p, nr_b, nc_p, nc_b, vi_p, vi_b;
  logic [1:0] hs_p, hs_b;

  int vectors = 0;
  int fails = 0;
  int nv_p = 0, nv_b = 0, nt_p = 0, nt_b = 0;
  logic [15:0] got_p, got_b;

  always #5 clk = ~clk;

  adc_hs_ctrl #(.BYTE_MODE(1'b1), .CONV_LOW_CYC(CONV_LOW), .RD_LOW_CYC(RD_LOW),
                .RD_GAP_CYC(GAP), .INT_TIMEOUT_CYC(TMO)) i_adc_hs_ctrl (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .result_valid(valid_b),
    .result_data(data_b), .timeout_err(to_b), .conv_start_n(conv_b), .cs_n(cs_b),
    .rd_n(rd_b), .hben(hb_b), .int_n(int_b), .adc_bus(bus_b));

  adc_hs_ctrl #(.BYTE_MODE(1'b0), .CONV_LOW_CYC(CONV_LOW), .RD_LOW_CYC(RD_LOW),
                .RD_GAP_CYC(GAP), .INT_TIMEOUT_CYC(TMO)) i_adc_hs_ctrl_par (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .result_valid(valid_p),
    .result_data(data_p), .timeout_err(to_p), .conv_start_n(conv_p), .cs_n(cs_p),
    .rd_n(rd_p), .hben(hb_p), .int_n(int_p), .adc_bus(bus_p));

  adc_conv_model #(.CONV_CYC(10), .BYTE(1'b1)) u_mdl_b (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_b), .cs_n(cs_b), .rd_n(rd_b), .hben(hb_b),
    .sample(sample), .hold(hold), .pwr_low(pwr_low), .int_n(int_b), .bus(bus_b),
    .conv_w(cw_b), .rd_w(rw_b), .gap_w(gw_b), .n_reads(nr_b), .n_convs(nc_b),
    .viol(vi_b), .hben_seq(hs_b));

  adc_conv_model #(.CONV_CYC(10), .BYTE(1'b0)) u_mdl_p (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_p), .cs_n(cs_p), .rd_n(rd_p), .hben(hb_p),
    .sample(sample), .hold(hold), .pwr_low(pwr_low), .int_n(int_p), .bus(bus_p),
    .conv_w(cw_p), .rd_w(rw_p), .gap_w(gw_p), .n_reads(nr_p), .n_convs(nc_p),
    .viol(vi_p), .hben_seq(hs_p));

  always @(posedge clk) begin
    if (valid_p) begin nv_p <= nv_p + 1; got_p <= data_p; end
    if (valid_b) begin nv_b <= nv_b + 1; got_b <= data_b; end
    if (to_p) nt_p <= nt_p + 1;
    if (to_b) nt_b <= nt_b + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  // one conversion on both instances, then check against the sample
  task automatic convert(input logic [13:0] v);
    int vp0, vb0, np0, nb0;
    logic [15:0] exp_b;
    @(negedge clk) sample = v;
    vp0 = nv_p; vb0 = nv_b; np0 = nr_p; nb0 = nr_b;
    pulse_start();
    for (int k = 0; k < 300 && !(nv_p > vp0 && nv_b > vb0); k++) @(negedge clk);
    repeat (GAP + 2) @(negedge clk);
    exp_b = {2'b00, v[13:8], v[7:0]};
    chk("R5 parallel word", got_p, {2'b00, v});
    chk("R6 byte word", got_b, exp_b);
    chk("R7 valid count par", nv_p - vp0, 1);
    chk("R7 valid count byte", nv_b - vb0, 1);
    chk("R2 start width par", cw_p, CONV_LOW);
    chk("R2 start width byte", cw_b, CONV_LOW);
    chk("R4 strobe width par", rw_p, RD_LOW);
    chk("R4 strobe width byte", rw_b, RD_LOW);
    chk("R5 reads per conv", nr_p - np0, 1);
    chk("R6 reads per conv", nr_b - nb0, 2);
    chk("R6 read gap", gw_b, GAP);
    chk("R6 hben order", hs_b, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end actual=hung expected=done");
    finish_run();
  end

  initial begin
    int r0p, r0b, v0p, v0b, c0p, c0b;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 conv_start_n", {conv_p, conv_b}, 2'b11);
    chk("R1 cs_n rd_n", {cs_p, rd_p, cs_b, rd_b}, 4'hF);
    chk("R1 hben valid to", {hb_p, hb_b, valid_p, valid_b, to_p, to_b}, 6'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle after reset", {conv_p, conv_b, cs_p, cs_b}, 4'hF);
    chk("R10 no dummy read when int high", nr_p + nr_b, 0);

    // walking ones and corner codes
    convert(14'h0000);
    convert(14'h3FFF);
    convert(14'h2AAA);
    convert(14'h1555);
    for (int b = 0; b < 14; b++) convert(14'(1 << b));
    for (int b = 0; b < 14; b++) convert(~14'(1 << b));
    // dense arithmetic sweep
    for (int i = 0; i < 200; i++) convert(14'((i * 1237 + 5) & 16'h3FFF));

    // R8: start requests during a transaction are ignored
    c0p = nc_p; c0b = nc_b; v0p = nv_p; v0b = nv_b;
    @(negedge clk) sample = 14'h1234;
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (9) @(negedge clk);
    pulse_start();
    repeat (80) @(negedge clk);
    chk("R8 one start par", nc_p - c0p, 1);
    chk("R8 one start byte", nc_b - c0b, 1);
    chk("R8 one result par", nv_p - v0p, 1);
    chk("R8 one result byte", nv_b - v0b, 1);
    chk("R8 data par", got_p, 16'h1234);
    chk("R8 data byte", got_b, 16'h1234);

    // R9: interrupt never arrives
    hold = 1'b1;
    r0p = nr_p; r0b = nr_b; v0p = nv_p; v0b = nv_b;
    pulse_start();
    repeat (TMO + 30) @(negedge clk);
    chk("R9 timeout pulse par", nt_p, 1);
    chk("R9 timeout pulse byte", nt_b, 1);
    chk("R9 no read", (nr_p - r0p) + (nr_b - r0b), 0);
    chk("R9 no result", (nv_p - v0p) + (nv_b - v0b), 0);
    hold = 1'b0;
    repeat (5) @(negedge clk);
    convert(14'h0F0F);

    // R10: interrupt stuck low at power-up
    pwr_low = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset again", {conv_p, conv_b, cs_p, cs_b, hb_b}, 5'h1E);
    r0p = nr_p; r0b = nr_b; v0p = nv_p; v0b = nv_b;
    rst_n = 1'b1;
    pwr_low = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 one dummy read par", nr_p - r0p, 1);
    chk("R10 one dummy read byte", nr_b - r0b, 1);
    chk("R10 dummy hben low", hs_b[0], 1'b0);
    chk("R10 no result", (nv_p - v0p) + (nv_b - v0b), 0);
    chk("R10 int released", {int_p, int_b}, 2'b11);
    convert(14'h3C5A);

    // R3 and R11: protocol monitors in the models
    chk("R3 protocol par", vi_p, 0);
    chk("R3 protocol byte", vi_b, 0);
    chk("R11 hben held through reads", hs_b, 2'b01);
    finish_run();
  end
endmodule